// File: doc/BRIEF.md
# Cross-Coupled Dual Interrupt Aggregator

This block holds two interrupt aggregators. One serves an embedded processor and one serves an external host. Each aggregator collects a fixed group of event sources into one pending vector: crypto context completions, command mailbox writes, DMA progress, memory conflicts and crypto errors. It then drives a single registered interrupt line from the masked part of that vector. Software sees each aggregator through a small register window. The window holds a mask, a per-source mode selection, a raw pending view, a masked pending view, a write-one-to-clear register and a write-one-to-set (force) register.

The two aggregators feed each other. Source 0 of each side is the registered interrupt output of the other side. The processor can therefore take an interrupt whenever the host side raises its line, and the reverse also holds. There is no combinational path between the two lines.

Each source is either edge-latched or level-following. An edge-latched source records a rising edge and holds it until software clears it. A level-following source copies the present input, delayed by one clock.

Top module: `xirq_pair`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are as follows: every mask, mode and pending bit reads 0, `proc_irq` and `host_irq` are low, and `reg_rdata` is 0 at every address.
- R2: The register address is formed as follows. `reg_addr[3]` selects the side, with 0 for the processor and 1 for the host. `reg_addr[2:0]` selects the register: 0 mask (read/write), 1 mode (read/write, 1 = edge), 2 raw pending (read-only), 3 masked pending (read-only), 4 clear (write-only), 5 force (write-only). Offsets 4 to 7 read as 0. Writes to offsets 2, 3, 6 and 7 change nothing. Bits above a side's source count read as 0.
- R3: A source in edge mode sets its pending bit at the clock edge where the input is high and was low at the previous edge. The bit then stays set while the input stays high or falls, until it is cleared.
- R4: Writing 1 to a clear bit resets an edge-mode pending bit at that edge. Writing 0 leaves it unchanged. A rising edge or force on the same bit in the same cycle wins over the clear.
- R5: Writing 1 to a force bit sets the pending bit at that edge. In edge mode the bit then holds. In level mode it lasts one cycle unless the input is high.
- R6: A source in level mode has a pending bit equal to its input as sampled at the previous clock edge. Clear writes do not affect it.
- R7: The masked view equals the raw view AND the mask. The mask has no effect on the raw view.
- R8: Each interrupt output is registered. It is high in the cycle after the one in which any masked pending bit of its side is set, and low in the cycle after the one in which none is set.
- R9: Processor source 0 is `host_irq`, and host source 0 is `proc_irq`. Each is taken from the registered output.
- R10: The processor sources are `proc_evt[k]` on bit k+1, in this order: context 1 done, context 0 done, host wrote command, DMA done, DMA queued, memory conflict, crypto error. The host sources are `host_evt[k]` on bit k+1, in this order: context 1 done, context 0 done, processor wrote command, crypto error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Side select (bit 3) and register offset (bits 2:0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| proc_evt | input | 7 | Processor-side event inputs, sources 1 to 7 |
| host_evt | input | 4 | Host-side event inputs, sources 1 to 4 |
| proc_irq | output | 1 | Registered interrupt toward the processor |
| host_irq | output | 1 | Registered interrupt toward the host |

## Verification
The bench targets several corner cases, and each one shows up as a specific failure:

- **Clear in the same cycle as a new edge.** A design where the clear wins would lose that event.
- **Input held high in edge mode.** A design that tests level instead of edge would re-latch the bit right after it is cleared.
- **Force in level mode.** A design that treats it as sticky would leave the line stuck high.
- **Cross-coupled ring with both bit-0 sources unmasked.** A design that used the unregistered combine would show the wrong latency.
- **Mask changes.** A design that gated the raw view with the mask would show masked bits missing from the raw read.

A long random stretch then mixes mode flips, forces, clears and event toggles against the cycle-level model.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [2:0] {
    OFS_MASK = 3'd0,
    OFS_MODE = 3'd1,
    OFS_RAW  = 3'd2,
    OFS_MSKD = 3'd3,
    OFS_CLR  = 3'd4,
    OFS_FRC  = 3'd5
  } reg_ofs_e;

  // Next pending value of one source for the chosen mode.
  function automatic logic next_pend(input logic edge_md, input logic cur,
                                     input logic rise, input logic clr,
                                     input logic frc, input logic src);
    if (edge_md) return (cur & ~clr) | rise | frc;
    return src | frc;
  endfunction
endpackage

// File: rtl/xirq_src_cell.sv
module xirq_src_cell
  import xirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic edge_md,
  input  logic clr,
  input  logic frc,
  output logic pend
);
  logic src_q;
  logic rise_evt;

  assign rise_evt = src & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      src_q <= src;
      pend  <= next_pend(edge_md, pend, rise_evt, clr, frc, src);
    end
  end

  // R3
  edge_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && !pend && !rise_evt && !frc) |=> !pend);
  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && pend && !clr) |=> pend);
  // R4
  clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && clr && !rise_evt && !frc) |=> !pend);
  // R5
  frc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> pend);
  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_md && !frc) |=> (pend == $past(src)));
endmodule

// File: rtl/xirq_collector.sv
module xirq_collector #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         we_mask,
  input  logic         we_mode,
  input  logic         we_clr,
  input  logic         we_frc,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mode_q,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] clr_vec;
  logic [N-1:0] frc_vec;
  logic         any_masked;

  assign clr_vec    = we_clr ? wdata : '0;
  assign frc_vec    = we_frc ? wdata : '0;
  assign any_masked = |(pend & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (we_mask) mask_q <= wdata;
      if (we_mode) mode_q <= wdata;
      irq <= any_masked;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    xirq_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src[i]),
      .edge_md (mode_q[i]),
      .clr     (clr_vec[i]),
      .frc     (frc_vec[i]),
      .pend    (pend[i])
    );
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_masked |=> irq);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_masked |=> !irq);
endmodule

// File: rtl/xirq_pair.sv
module xirq_pair
  import xirq_pkg::*;
#(
  parameter int P_N = 8,
  parameter int H_N = 5,
  parameter int DW  = (P_N > H_N) ? P_N : H_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [P_N-2:0]    proc_evt,
  input  logic [H_N-2:0]    host_evt,
  output logic              proc_irq,
  output logic              host_irq
);
  logic     side_h;
  reg_ofs_e ofs;
  logic     p_wr, h_wr;
  logic [P_N-1:0] p_src, p_mask, p_mode, p_pend;
  logic [H_N-1:0] h_src, h_mask, h_mode, h_pend;

  assign side_h = reg_addr[3];
  assign ofs    = reg_ofs_e'(reg_addr[2:0]);
  assign p_wr   = reg_we & ~side_h;
  assign h_wr   = reg_we & side_h;

  assign p_src = {proc_evt, host_irq};
  assign h_src = {host_evt, proc_irq};

  xirq_collector #(.N(P_N)) u_proc (
    .clk(clk), .rst_n(rst_n), .src(p_src),
    .we_mask(p_wr && ofs == OFS_MASK), .we_mode(p_wr && ofs == OFS_MODE),
    .we_clr(p_wr && ofs == OFS_CLR), .we_frc(p_wr && ofs == OFS_FRC),
    .wdata(reg_wdata[P_N-1:0]),
    .mask_q(p_mask), .mode_q(p_mode), .pend(p_pend), .irq(proc_irq)
  );

  xirq_collector #(.N(H_N)) u_host (
    .clk(clk), .rst_n(rst_n), .src(h_src),
    .we_mask(h_wr && ofs == OFS_MASK), .we_mode(h_wr && ofs == OFS_MODE),
    .we_clr(h_wr && ofs == OFS_CLR), .we_frc(h_wr && ofs == OFS_FRC),
    .wdata(reg_wdata[H_N-1:0]),
    .mask_q(h_mask), .mode_q(h_mode), .pend(h_pend), .irq(host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (!side_h) begin
      case (ofs)
        OFS_MASK: reg_rdata[P_N-1:0] = p_mask;
        OFS_MODE: reg_rdata[P_N-1:0] = p_mode;
        OFS_RAW:  reg_rdata[P_N-1:0] = p_pend;
        OFS_MSKD: reg_rdata[P_N-1:0] = p_pend & p_mask;
        default:  reg_rdata = '0;
      endcase
    end else begin
      case (ofs)
        OFS_MASK: reg_rdata[H_N-1:0] = h_mask;
        OFS_MODE: reg_rdata[H_N-1:0] = h_mode;
        OFS_RAW:  reg_rdata[H_N-1:0] = h_pend;
        OFS_MSKD: reg_rdata[H_N-1:0] = h_pend & h_mask;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R9
  cross_h2p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !p_mode[0]) |=> p_pend[0]);
  // R9
  cross_p2h_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_irq && !h_mode[0]) |=> h_pend[0]);
endmodule

// File: tb/xirq_pair_bench.sv
module xirq_pair_bench;
  localparam int PN = 8;
  localparam int HN = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [PN-2:0] proc_evt = '0;
  logic [HN-2:0] host_evt = '0;
  logic proc_irq, host_irq;

  always #10 clk = ~clk;

  xirq_pair u_xirq_pair (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .proc_evt(proc_evt),
    .host_evt(host_evt), .proc_irq(proc_irq), .host_irq(host_irq)
  );

  // reference state
  logic [PN-1:0] m_pmask = '0, m_pmode = '0, m_ppend = '0, m_psq = '0;
  logic [HN-1:0] m_hmask = '0, m_hmode = '0, m_hpend = '0, m_hsq = '0;
  logic m_pirq = 1'b0, m_hirq = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    logic [PN-1:0] ps, pc, pf, np;
    logic [HN-1:0] hs, hc, hf, nh;
    logic npi, nhi;
    if (!rst_n) begin
      m_pmask = '0; m_pmode = '0; m_ppend = '0; m_psq = '0;
      m_hmask = '0; m_hmode = '0; m_hpend = '0; m_hsq = '0;
      m_pirq = 0; m_hirq = 0;
    end else begin
      ps = {proc_evt, m_hirq};
      hs = {host_evt, m_pirq};
      pc = (reg_we && !reg_addr[3] && reg_addr[2:0] == 3'd4) ? reg_wdata[PN-1:0] : '0;
      pf = (reg_we && !reg_addr[3] && reg_addr[2:0] == 3'd5) ? reg_wdata[PN-1:0] : '0;
      hc = (reg_we && reg_addr[3] && reg_addr[2:0] == 3'd4) ? reg_wdata[HN-1:0] : '0;
      hf = (reg_we && reg_addr[3] && reg_addr[2:0] == 3'd5) ? reg_wdata[HN-1:0] : '0;
      for (int i = 0; i < PN; i++) begin
        if (m_pmode[i]) np[i] = (m_ppend[i] && !pc[i]) || (ps[i] && !m_psq[i]) || pf[i];
        else            np[i] = ps[i] || pf[i];
      end
      for (int i = 0; i < HN; i++) begin
        if (m_hmode[i]) nh[i] = (m_hpend[i] && !hc[i]) || (hs[i] && !m_hsq[i]) || hf[i];
        else            nh[i] = hs[i] || hf[i];
      end
      npi = (m_ppend & m_pmask) != 0;
      nhi = (m_hpend & m_hmask) != 0;
      if (reg_we && !reg_addr[3] && reg_addr[2:0] == 3'd0) m_pmask = reg_wdata[PN-1:0];
      if (reg_we && !reg_addr[3] && reg_addr[2:0] == 3'd1) m_pmode = reg_wdata[PN-1:0];
      if (reg_we && reg_addr[3] && reg_addr[2:0] == 3'd0) m_hmask = reg_wdata[HN-1:0];
      if (reg_we && reg_addr[3] && reg_addr[2:0] == 3'd1) m_hmode = reg_wdata[HN-1:0];
      m_psq = ps; m_hsq = hs; m_ppend = np; m_hpend = nh;
      m_pirq = npi; m_hirq = nhi;
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [3:0] a);
    logic [DW-1:0] r = '0;
    if (!a[3]) begin
      case (a[2:0])
        3'd0: r = m_pmask;
        3'd1: r = m_pmode;
        3'd2: r = m_ppend;
        3'd3: r = m_ppend & m_pmask;
        default: r = '0;
      endcase
    end else begin
      case (a[2:0])
        3'd0: r[HN-1:0] = m_hmask;
        3'd1: r[HN-1:0] = m_hmode;
        3'd2: r[HN-1:0] = m_hpend;
        3'd3: r[HN-1:0] = m_hpend & m_hmask;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("proc_irq", {7'd0, proc_irq}, {7'd0, m_pirq});
      chk("host_irq", {7'd0, host_irq}, {7'd0, m_hirq});
      chk($sformatf("rdata@%h", reg_addr), reg_rdata, exp_rd(reg_addr));
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #4;
      reg_we = 0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(posedge clk); #4;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #4;
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(posedge clk); #4;
    reg_we = 0; reg_addr = a;
  endtask

  initial begin
    // R1: reset state, reads at every address
    cur_req = "R1";
    for (int a = 0; a < 16; a++) rd(4'(a));
    @(posedge clk); #4; rst_n = 1;
    for (int a = 0; a < 16; a++) rd(4'(a));

    // R2: register map, read-only and write-only behaviour
    cur_req = "R2";
    wr(4'h0, 8'hA5); rd(4'h0);
    wr(4'h8, 8'hFF); rd(4'h8);
    wr(4'h1, 8'h3C); rd(4'h1);
    wr(4'h9, 8'h0A); rd(4'h9);
    wr(4'h2, 8'hFF); rd(4'h2);
    wr(4'hB, 8'hFF); rd(4'hB);
    wr(4'h6, 8'hFF); wr(4'hF, 8'hFF);
    rd(4'h4); rd(4'h5); rd(4'hC); rd(4'hD); rd(4'h7);
    wr(4'h0, 8'h00); wr(4'h8, 8'h00); wr(4'h1, 8'h00); wr(4'h9, 8'h00);
    wr(4'hC, 8'hFF); wr(4'h4, 8'hFF);

    // R3: edge latching, held-high input does not re-latch
    cur_req = "R3";
    wr(4'h1, 8'hFE); wr(4'h0, 8'hFE); rd(4'h2);
    proc_evt = 7'b0000001; cyc(3);
    proc_evt = 7'b0000000; cyc(3);
    proc_evt = 7'b1000000; cyc(2);
    wr(4'h4, 8'h80); cyc(3);
    proc_evt = 7'b0; cyc(2);

    // R4: clear semantics, zero-bit clear, clear against same-cycle edge
    cur_req = "R4";
    wr(4'h4, 8'h00); rd(4'h2);
    wr(4'h4, 8'h02); rd(4'h2);
    @(posedge clk); #4;
    reg_we = 1; reg_addr = 4'h4; reg_wdata = 8'h04; proc_evt = 7'b0000010;
    @(posedge clk); #4;
    reg_we = 0; reg_addr = 4'h2;
    cyc(2);
    proc_evt = 7'b0; wr(4'h4, 8'hFF); rd(4'h2);

    // R5: force in edge and level modes
    cur_req = "R5";
    wr(4'h5, 8'h10); rd(4'h2); cyc(2);
    wr(4'h4, 8'h10);
    wr(4'h1, 8'h00); wr(4'h5, 8'h20); rd(4'h2); cyc(2);

    // R6: level mode follows input, clear ignored
    cur_req = "R6";
    proc_evt = 7'b0101010; cyc(2);
    wr(4'h4, 8'hFF); rd(4'h2);
    proc_evt = 7'b1010101; cyc(2);
    proc_evt = 7'b0; cyc(2);

    // R7: masked view and mask independence of raw view
    cur_req = "R7";
    proc_evt = 7'b1111111;
    wr(4'h0, 8'h0F); rd(4'h3); rd(4'h2);
    wr(4'h0, 8'h00); rd(4'h3); rd(4'h2);
    wr(4'h0, 8'hF0); rd(4'h3);

    // R8: output timing on mask and input changes
    cur_req = "R8";
    proc_evt = 7'b0; cyc(3);
    proc_evt = 7'b0000100; cyc(3);
    wr(4'h0, 8'h00); cyc(2);

    // R9: cross-coupling in both directions and the ring
    cur_req = "R9";
    wr(4'h8, 8'h01); wr(4'h0, 8'h04);
    proc_evt = 7'b0000010; cyc(3); rd(4'hA); cyc(2);
    proc_evt = 7'b0; cyc(3);
    wr(4'h0, 8'h01); wr(4'h8, 8'h10);
    host_evt = 4'b1000; cyc(3); rd(4'h2); cyc(2);
    wr(4'h8, 8'h11); cyc(4);
    host_evt = 4'b0; cyc(6);

    // R10: every source bit alone on each side
    cur_req = "R10";
    wr(4'h1, 8'hFF); wr(4'h9, 8'h1F); wr(4'h4, 8'hFF); wr(4'hC, 8'hFF);
    wr(4'h0, 8'hFF); wr(4'h8, 8'h1F);
    for (int k = 0; k < PN - 1; k++) begin
      proc_evt = 7'(1 << k); rd(4'h2); cyc(1);
      proc_evt = 7'b0; wr(4'h4, 8'hFF);
    end
    for (int k = 0; k < HN - 1; k++) begin
      host_evt = 4'(1 << k); rd(4'hA); cyc(1);
      host_evt = 4'b0; wr(4'hC, 8'hFF);
    end

    // R8: random mix of everything against the model
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #4;
      reg_we    = ($urandom % 3) == 0;
      reg_addr  = 4'($urandom);
      reg_wdata = 8'($urandom);
      if (($urandom % 2) == 0) proc_evt = 7'($urandom);
      if (($urandom % 2) == 0) host_evt = 4'($urandom);
    end
    reg_we = 0;
    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule